// File: doc/BRIEF.md
# Wallace Tree Unsigned Multiplier

This block multiplies two 12-bit unsigned operands and gives a 24-bit product. The multiplier operand gates the multiplicand to form twelve partial-product rows, each shifted by its bit position. Carry-save compressors then reduce the rows in parallel, level by level. The last two rows go to a carry-propagate adder. The reduction schedule is fixed. The row count falls 12, 8, 6, 4, 3, 2 over five compressor levels. At each level, rows that do not fill a group of three pass straight down to the next level.

An output register with a synchronous reset is on by default. It holds the product of the operands that were present at the previous rising clock edge. If the register is disabled through a parameter, the product is the combinational result.

Top module: `wt_mult12`

## Requirements
- R1: With the output register enabled, the product output equals opA*opB (unsigned, 24 bits) after the first rising edge at which those operands are present and reset is low.
- R2: Partial-product row i is opA shifted left by i and zero-extended to 24 bits when opB bit i is 1, and zero otherwise. A multiplier with a single bit i set yields opA shifted left by i.
- R3: Each 3-to-2 compressor keeps the column-weighted sum of its three input rows modulo 2^24. Its carry row is shifted up by one bit, and any bit beyond bit 23 is dropped. The largest operands (4095*4095 = 16769025) produce the correct product.
- R4: Rows that do not fill a group of three at a level pass unchanged to the next level. This applies to level 1, where the rows from partial products 9 to 11 pass, and to level 3. Products whose multiplier bits lie only in bits 9 to 11 are exact.
- R5: Reset is synchronous and active high. A rising edge with reset high clears the product to 0, whatever the operands. Reset takes priority over capturing a new product in the same cycle.
- R6: A zero operand on either input gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opA | input | 12 | Multiplicand, unsigned |
| opB | input | 12 | Multiplier, unsigned |
| product | output | 24 | Unsigned product opA*opB |

## Verification
Two functions can fall in the same cycle: clearing the output register on reset, and capturing a newly computed product. The bench provokes this by raising reset at a clock edge while the largest operands are applied, so a new product is ready to be captured. It judges the outcome by requiring that the register reads 0 after that edge and takes up the correct product again one edge after reset is released. The arithmetic is judged with sweeps against a multiply computed in the bench:
- every multiplicand with each single-bit multiplier;
- every multiplicand against zero, and zero against every multiplier;
- the all-ones multiplicand against every multiplier;
- multipliers that use only the passing rows;
- random pairs.

// File: rtl/wt_pkg.sv
package wt_pkg;
  parameter int OP_W   = 12;
  parameter int PROD_W = 2 * OP_W;
  parameter int ROWS   = OP_W;

  typedef logic [PROD_W-1:0] wt_row_t;

  typedef struct packed {
    logic clear;
    logic capture;
  } wt_strobe_t;
endpackage

// File: rtl/wt_csa.sv
module wt_csa #(
  parameter int W = 24
) (
  input  logic [W-1:0] inX,
  input  logic [W-1:0] inY,
  input  logic [W-1:0] inZ,
  output logic [W-1:0] sumRow,
  output logic [W-1:0] carryRow
);
  logic [W-1:0] majority;

  assign sumRow   = inX ^ inY ^ inZ;
  assign majority = (inX & inY) | (inX & inZ) | (inY & inZ);
  assign carryRow = {majority[W-2:0], 1'b0};

  // R3: the compressor keeps the weighted total of its inputs, modulo 2^W
  always_comb begin
    if (!$isunknown({inX, inY, inZ})) begin
      assert_csa_total_R3: assert (W'(sumRow + carryRow) == W'(inX + inY + inZ))
        else $error("compressor total mismatch");
    end
  end
endmodule

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
(
  input  logic       rst,
  output wt_strobe_t strobe
);
  // R5: reset clears the register and blocks capture in the same cycle
  always_comb begin
    strobe.clear   = rst;
    strobe.capture = ~rst;
  end
endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  wt_strobe_t      strobe,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic [PROD_W-1:0] product
);
  localparam int L1_ROWS = 8;
  localparam int L2_ROWS = 6;
  localparam int L3_ROWS = 4;
  localparam int L4_ROWS = 3;
  localparam int L5_ROWS = 2;

  wt_row_t rowsL0 [ROWS];
  wt_row_t rowsL1 [L1_ROWS];
  wt_row_t rowsL2 [L2_ROWS];
  wt_row_t rowsL3 [L3_ROWS];
  wt_row_t rowsL4 [L4_ROWS];
  wt_row_t rowsL5 [L5_ROWS];
  wt_row_t sumAll;

  // R2: partial-product rows, gated and shifted
  for (genvar i = 0; i < ROWS; i++) begin : g_pp
    assign rowsL0[i] = {{(PROD_W-OP_W){1'b0}}, opA & {OP_W{opB[i]}}} << i;
  end

  // Level 0: four groups, twelve rows down to eight
  for (genvar g = 0; g < 4; g++) begin : g_lv0
    wt_csa #(.W(PROD_W)) u_csa (
      .inX(rowsL0[3*g]), .inY(rowsL0[3*g+1]), .inZ(rowsL0[3*g+2]),
      .sumRow(rowsL1[2*g]), .carryRow(rowsL1[2*g+1]));
  end

  // Level 1: two groups, two rows pass (R4)
  for (genvar g = 0; g < 2; g++) begin : g_lv1
    wt_csa #(.W(PROD_W)) u_csa (
      .inX(rowsL1[3*g]), .inY(rowsL1[3*g+1]), .inZ(rowsL1[3*g+2]),
      .sumRow(rowsL2[2*g]), .carryRow(rowsL2[2*g+1]));
  end
  assign rowsL2[4] = rowsL1[6];
  assign rowsL2[5] = rowsL1[7];

  // Level 2: two groups, six rows down to four
  for (genvar g = 0; g < 2; g++) begin : g_lv2
    wt_csa #(.W(PROD_W)) u_csa (
      .inX(rowsL2[3*g]), .inY(rowsL2[3*g+1]), .inZ(rowsL2[3*g+2]),
      .sumRow(rowsL3[2*g]), .carryRow(rowsL3[2*g+1]));
  end

  // Level 3: one group, one row passes (R4)
  wt_csa #(.W(PROD_W)) u_csaLv3 (
    .inX(rowsL3[0]), .inY(rowsL3[1]), .inZ(rowsL3[2]),
    .sumRow(rowsL4[0]), .carryRow(rowsL4[1]));
  assign rowsL4[2] = rowsL3[3];

  // Level 4: last compression to two rows
  wt_csa #(.W(PROD_W)) u_csaLv4 (
    .inX(rowsL4[0]), .inY(rowsL4[1]), .inZ(rowsL4[2]),
    .sumRow(rowsL5[0]), .carryRow(rowsL5[1]));

  // Carry-propagate adder
  assign sumAll = rowsL5[0] + rowsL5[1];

  // R4: the two surviving rows carry the full product
  always_comb begin
    if (!$isunknown({opA, opB})) begin
      assert_tree_total_R4: assert (sumAll == PROD_W'(PROD_W'(opA) * PROD_W'(opB)))
        else $error("tree total mismatch");
    end
  end

  // R5: clear and capture are never requested together
  always_comb begin
    if (!$isunknown(strobe)) begin
      assert_clear_wins_R5: assert (!(strobe.clear && strobe.capture))
        else $error("clear and capture both set");
    end
  end

  if (REG_OUT) begin : g_reg
    wt_row_t prodQ;
    always_ff @(posedge clk) begin
      if (strobe.clear)        prodQ <= '0;
      else if (strobe.capture) prodQ <= sumAll;
    end
    assign product = prodQ;
  end else begin : g_comb
    assign product = sumAll;
  end
endmodule

// File: rtl/wt_mult12.sv
module wt_mult12
  import wt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [PROD_W-1:0] product
);
  wt_strobe_t strobe;

  wt_ctrl u_ctrl (
    .rst   (rst),
    .strobe(strobe)
  );

  wt_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );

  if (REG_OUT) begin : g_chk
    logic [PROD_W-1:0] refProd;
    assign refProd = PROD_W'(PROD_W'(opA) * PROD_W'(opB));

    // R1: registered product follows the operands by one edge
    assert_reg_product_R1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> product == $past(refProd))
      else $error("registered product mismatch");

    // R6: a zero operand yields zero
    assert_zero_operand_R6: assert property (@(posedge clk) disable iff (rst)
      (opA == '0 || opB == '0) |=> product == '0)
      else $error("zero operand gave nonzero product");
  end
endmodule

// File: tb/wt_mult12_bench.sv
`timescale 1ns/1ps
module wt_mult12_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] opA = '0;
  logic [11:0] opB = '0;
  logic [23:0] product;
  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  wt_mult12 u_wt_mult12 (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .product(product)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runVec(input logic [11:0] a, input logic [11:0] b, input string req);
    @(negedge clk);
    opA = a;
    opB = b;
    @(posedge clk);
    #1;
    check(req, product, 24'(a) * 24'(b));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R5: reset state
    opA = 12'hFFF; opB = 12'hFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset state", product, 24'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: basic corner operands
    runVec(12'd1, 12'd1, "R1 one*one");
    runVec(12'd3, 12'd5, "R1 small");
    runVec(12'd4095, 12'd1, "R1 max*one");

    // R3: largest operands, longest carry chains
    runVec(12'd4095, 12'd4095, "R3 max*max");

    // R2: every multiplicand with each single-bit multiplier
    for (int i = 0; i < 12; i++) begin
      for (int a = 0; a < 4096; a++) begin
        runVec(12'(a), 12'(1 << i), "R2 single-bit");
      end
    end

    // R6: zero on either side
    for (int a = 0; a < 4096; a++) runVec(12'(a), 12'd0, "R6 zero multiplier");
    for (int b = 0; b < 4096; b++) runVec(12'd0, 12'(b), "R6 zero multiplicand");

    // R3: all-ones multiplicand over every multiplier
    for (int b = 0; b < 4096; b++) runVec(12'hFFF, 12'(b), "R3 all-ones sweep");

    // R4: multipliers using only rows 9..11 (pass-through at level 1)
    for (int k = 1; k < 8; k++) begin
      for (int a = 0; a < 4096; a += 3) runVec(12'(a), 12'(k << 9), "R4 pass rows");
    end

    // R5: reset and capture in the same cycle
    runVec(12'd100, 12'd200, "R1 before reset");
    @(negedge clk);
    rst = 1'b1; opA = 12'hFFF; opB = 12'hFFF;
    @(posedge clk);
    #1;
    check("R5 reset beats capture", product, 24'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R5 capture after release", product, 24'd16769025);

    // R1: random operand pairs
    for (int n = 0; n < 30000; n++) begin
      runVec(12'($urandom), 12'($urandom), "R1 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule